// File: doc/BRIEF.md
# Hash Input Word Aligner

This block turns 32-bit words arriving on a write-only data port into a stream of single bytes for a byte-oriented hash core. Each word passes through one of four byte-order permutations chosen at configuration time, and the bytes leave one per cycle under a valid/ready handshake. The input carries no per-byte valid mask. The block therefore takes a message length in bits, converts it to bytes, and uses it to decide how many bytes of the final word are real. Every earlier word counts as four full bytes.

Software issues a configuration pulse that carries the byte order and the 64-bit bit length, waits the required gap, and then writes the message words. The block marks the final byte, pulses an end-of-message strobe, and raises a write-error strobe for any word it has to discard. A word is discarded when it arrives before any configuration, or when it arrives after the whole message has been taken in. A zero-length message ends at once and emits no bytes.

Top module: `hash_word_aligner`

## Requirements
- R1: After reset, byte_valid, byte_last, msg_done and wr_err are 0, and wd_ready is 1 because the block is unconfigured.
- R2: Byte order `cfg_order` sets the output sequence of input lanes, where lane k is `wd_data[8k+7:8k]`. Encoding 0 sends lanes 3,2,1,0. Encoding 1 sends 0,1,2,3. Encoding 2 sends 2,3,1,0. Encoding 3 sends 1,0,3,2.
- R3: Every word except the last word of a message yields exactly four output bytes.
- R4: The byte length is `cfg_len_bits >> 3`, so the low three bits are ignored. The last word yields length minus four times the number of earlier words, which is 1 to 4 bytes.
- R5: A word accepted before any configuration since reset is dropped, produces no byte, and causes a one-cycle wr_err pulse in the next cycle.
- R6: wd_ready is 0 in the cycle where cfg_wr is high and in the two cycles after it, so no word is accepted in those cycles.
- R7: While byte_valid is high and byte_ready is low, byte_valid, byte_data and byte_last hold their values. While a non-final word is still draining, wd_ready stays 0.
- R8: byte_last is high only with the final byte of the message. msg_done pulses for one cycle, in the cycle after that byte's handshake.
- R9: A word accepted after the whole message length has been taken in is dropped and causes a one-cycle wr_err pulse in the next cycle.
- R10: A configuration with a byte length of zero pulses msg_done in the cycle after cfg_wr and emits no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_order | input | 2 | Byte-order select |
| cfg_len_bits | input | 64 | Message length in bits |
| wd_valid | input | 1 | Data word offered |
| wd_data | input | 32 | Data word |
| wd_ready | output | 1 | Data word may be taken this cycle |
| byte_valid | output | 1 | Output byte valid |
| byte_data | output | 8 | Output byte |
| byte_last | output | 1 | Final byte of the message |
| byte_ready | input | 1 | Core accepts the byte |
| msg_done | output | 1 | End-of-message pulse |
| wr_err | output | 1 | Dropped-write pulse |

## Verification
A word taken at a clock edge shows its first byte on byte_valid/byte_data right after that same edge, with no extra register stage. The bench drives on falling edges and samples on the next falling edge, so each byte is checked in the half cycle before it is consumed. wr_err and msg_done are registered, so each is checked at the falling edge that follows the handshake edge that caused it, and checked again one cycle later to confirm it has dropped. wd_ready is sampled at the three falling edges that follow the configuration edge: it must be low at the first two and high at the third.

// File: rtl/hwa_pkg.sv
package hwa_pkg;
  localparam int unsigned LANES = 4;

  // Input lane delivered at stream position pos for a given order select.
  function automatic logic [1:0] lane_sel(input logic [1:0] ord, input logic [1:0] pos);
    logic [1:0] r;
    case (ord)
      2'd0:    r = 2'd3 - pos;
      2'd1:    r = pos;
      2'd2:    r = (pos == 2'd0) ? 2'd2 : (pos == 2'd1) ? 2'd3 : (pos == 2'd2) ? 2'd1 : 2'd0;
      default: r = (pos == 2'd0) ? 2'd1 : (pos == 2'd1) ? 2'd0 : (pos == 2'd2) ? 2'd3 : 2'd2;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hwa_cfg.sv
module hwa_cfg #(
  parameter int LEN_W     = 64,
  parameter int GUARD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_order,
  input  logic [LEN_W-1:0] cfg_len_bits,
  input  logic             take,
  output logic             cfg_seen,
  output logic [1:0]       order_q,
  output logic             guard_busy,
  output logic             rem_zero,
  output logic [2:0]       take_n,
  output logic             take_last,
  output logic             zero_done
);
  localparam int BYTE_W = LEN_W - 3;
  localparam int GW     = $clog2(GUARD_CYC + 1);

  logic [BYTE_W-1:0] rem_q, rem_d;
  logic [GW-1:0]     grd_q, grd_d;
  logic              seen_d, zd_d;
  logic [1:0]        ord_d;
  logic              cfg_en;
  logic [2:0]        unused_lowbits;

  assign unused_lowbits = cfg_len_bits[2:0];
  assign cfg_en     = cfg_wr | take | (grd_q != '0) | zero_done;
  assign guard_busy = (grd_q != '0);
  assign rem_zero   = (rem_q == '0);
  assign take_last  = (rem_q <= BYTE_W'(4));
  assign take_n     = (rem_q >= BYTE_W'(4)) ? 3'd4 : rem_q[2:0];

  always_comb begin
    rem_d  = rem_q;
    grd_d  = grd_q;
    seen_d = cfg_seen;
    ord_d  = order_q;
    zd_d   = 1'b0;
    if (cfg_wr) begin
      seen_d = 1'b1;
      ord_d  = cfg_order;
      rem_d  = cfg_len_bits[LEN_W-1:3];
      grd_d  = GW'(GUARD_CYC);
      zd_d   = (cfg_len_bits[LEN_W-1:3] == '0);
    end else begin
      if (grd_q != '0) grd_d = grd_q - GW'(1);
      if (take)        rem_d = rem_q - BYTE_W'(take_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q     <= '0;
      grd_q     <= '0;
      cfg_seen  <= 1'b0;
      order_q   <= 2'd0;
      zero_done <= 1'b0;
    end else if (cfg_en) begin
      rem_q     <= rem_d;
      grd_q     <= grd_d;
      cfg_seen  <= seen_d;
      order_q   <= ord_d;
      zero_done <= zd_d;
    end
  end
endmodule

// File: rtl/hwa_lane_buf.sv
module hwa_lane_buf
  import hwa_pkg::*;
#(
  parameter int NLANE = LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [8*NLANE-1:0] load_word,
  input  logic [2:0]         load_n,
  input  logic               load_last,
  input  logic [1:0]         order,
  input  logic               byte_ready,
  output logic               empty,
  output logic               byte_valid,
  output logic [7:0]         byte_data,
  output logic               byte_last,
  output logic               last_fire
);
  logic [8*NLANE-1:0] perm, buf_q, buf_d;
  logic [2:0]         cnt_q, cnt_d;
  logic               last_q, last_d;
  logic               fire, buf_en;

  for (genvar p = 0; p < NLANE; p++) begin : g_perm
    assign perm[8*p +: 8] = load_word[8*lane_sel(order, 2'(p)) +: 8];
  end

  assign byte_valid = (cnt_q != 3'd0);
  assign empty      = ~byte_valid;
  assign byte_data  = buf_q[7:0];
  assign byte_last  = last_q & (cnt_q == 3'd1);
  assign fire       = byte_valid & byte_ready;
  assign last_fire  = fire & byte_last;
  assign buf_en     = load | fire;

  always_comb begin
    buf_d  = buf_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (load) begin
      buf_d  = perm;
      cnt_d  = load_n;
      last_d = load_last;
    end else if (fire) begin
      buf_d  = buf_q >> 8;
      cnt_d  = cnt_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cnt_q  <= 3'd0;
      last_q <= 1'b0;
    end else if (buf_en) begin
      buf_q  <= buf_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/hash_word_aligner.sv
module hash_word_aligner #(
  parameter int LEN_W     = 64,
  parameter int GUARD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_order,
  input  logic [LEN_W-1:0] cfg_len_bits,
  input  logic             wd_valid,
  input  logic [31:0]      wd_data,
  output logic             wd_ready,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             byte_last,
  input  logic             byte_ready,
  output logic             msg_done,
  output logic             wr_err
);
  logic       cfg_seen, guard_busy, rem_zero, take_last, zero_done;
  logic [1:0] order_q;
  logic [2:0] take_n;
  logic       buf_empty, last_fire;
  logic       wd_take, discard, load;
  logic       err_q, done_q;

  assign wd_ready = ~cfg_wr & (~cfg_seen | (~guard_busy & (rem_zero | buf_empty)));
  assign wd_take  = wd_valid & wd_ready;
  assign discard  = ~cfg_seen | rem_zero;
  assign load     = wd_take & ~discard;

  hwa_cfg #(.LEN_W(LEN_W), .GUARD_CYC(GUARD_CYC)) u_cfg (
    .clk, .rst_n, .cfg_wr, .cfg_order, .cfg_len_bits,
    .take(load), .cfg_seen, .order_q, .guard_busy, .rem_zero,
    .take_n, .take_last, .zero_done
  );

  hwa_lane_buf u_buf (
    .clk, .rst_n, .load, .load_word(wd_data), .load_n(take_n),
    .load_last(take_last), .order(order_q), .byte_ready,
    .empty(buf_empty), .byte_valid, .byte_data, .byte_last, .last_fire
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      err_q  <= wd_take & discard;
      done_q <= last_fire;
    end
  end

  assign wr_err   = err_q;
  assign msg_done = done_q | zero_done;
endmodule

// File: rtl/hwa_aligner_chk.sv
module hwa_aligner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       wd_valid,
  input logic       wd_ready,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_data,
  input logic       byte_last,
  input logic       msg_done,
  input logic       wr_err,
  input logic       cfg_seen
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data) && $stable(byte_last));

  p_guard1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr) |-> !wd_ready);

  p_guard2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr, 2) |-> !wd_ready);

  p_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid && wd_ready && !cfg_seen |=> wr_err && !byte_valid);

  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_ready && byte_last |=> msg_done);

  p_lastvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last |-> byte_valid);
endmodule

bind hash_word_aligner hwa_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wd_valid(wd_valid),
  .wd_ready(wd_ready), .byte_valid(byte_valid), .byte_ready(byte_ready),
  .byte_data(byte_data), .byte_last(byte_last), .msg_done(msg_done),
  .wr_err(wr_err), .cfg_seen(cfg_seen)
);

// File: tb/sim_hash_word_aligner.sv
`timescale 1ns/1ps
module sim_hash_word_aligner;
  logic        clk, rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_order;
  logic [63:0] cfg_len_bits;
  logic        wd_valid;
  logic [31:0] wd_data;
  logic        wd_ready, byte_valid, byte_last, byte_ready, msg_done, wr_err;
  logic [7:0]  byte_data;
  int          n_chk, n_fail;

  hash_word_aligner u0 (
    .clk, .rst_n, .cfg_wr, .cfg_order, .cfg_len_bits, .wd_valid, .wd_data,
    .wd_ready, .byte_valid, .byte_data, .byte_last, .byte_ready, .msg_done, .wr_err
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  ord;
    logic [7:0]  nbytes;
    logic [2:0]  extra;
    logic        stall;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] w2;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 8'd4,  3'd0, 1'b0, 32'h11223344, 32'h0, 32'h0},
    '{2'd1, 8'd5,  3'd0, 1'b0, 32'hA1B2C3D4, 32'h55667788, 32'h0},
    '{2'd2, 8'd6,  3'd0, 1'b1, 32'h0F1E2D3C, 32'h4B5A6978, 32'h0},
    '{2'd3, 8'd7,  3'd5, 1'b0, 32'hDEADBEEF, 32'hCAFEF00D, 32'h0},
    '{2'd0, 8'd8,  3'd0, 1'b1, 32'h01020304, 32'h05060708, 32'h0},
    '{2'd3, 8'd9,  3'd0, 1'b1, 32'h10203040, 32'h50607080, 32'h90A0B0C0},
    '{2'd1, 8'd10, 3'd7, 1'b0, 32'h13579BDF, 32'h2468ACE0, 32'hFEDCBA98},
    '{2'd2, 8'd3,  3'd0, 1'b0, 32'h89ABCDEF, 32'h0, 32'h0}
  };

  function automatic logic [7:0] exp_byte(input logic [1:0] o, input logic [31:0] w, input int pos);
    int seq0 [4] = '{3, 2, 1, 0};
    int seq1 [4] = '{0, 1, 2, 3};
    int seq2 [4] = '{2, 3, 1, 0};
    int seq3 [4] = '{1, 0, 3, 2};
    int lane;
    case (o)
      2'd0: lane = seq0[pos];
      2'd1: lane = seq1[pos];
      2'd2: lane = seq2[pos];
      default: lane = seq3[pos];
    endcase
    return w[8*lane +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic configure(input logic [1:0] o, input logic [63:0] bits);
    cfg_wr = 1'b1; cfg_order = o; cfg_len_bits = bits;
    #1 chk(wd_ready == 1'b0, "R6 ready during cfg", 64'(wd_ready), 0);
    @(negedge clk); cfg_wr = 1'b0;
    #1 chk(wd_ready == 1'b0, "R6 ready cfg+1", 64'(wd_ready), 0);
    chk(msg_done == ((bits >> 3) == 0), "R10 zero-length done", 64'(msg_done), 64'((bits >> 3) == 0));
    @(negedge clk);
    #1 chk(wd_ready == 1'b0, "R6 ready cfg+2", 64'(wd_ready), 0);
    chk(msg_done == 1'b0, "R10 done single pulse", 64'(msg_done), 0);
    @(negedge clk);
    #1 chk(wd_ready == 1'b1, "R6 ready cfg+3", 64'(wd_ready), 1);
  endtask

  task automatic send_word(input logic [31:0] d);
    wd_valid = 1'b1; wd_data = d;
    #1;
    while (!wd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wd_valid = 1'b0;
  endtask

  task automatic collect(input logic [31:0] w, input logic [1:0] o, input int n,
                         input bit is_last, input bit stall);
    for (int pos = 0; pos < n; pos++) begin
      if (stall && (pos % 2 == 0)) begin
        logic [7:0] held;
        byte_ready = 1'b0;
        held = byte_data;
        @(negedge clk);
        chk(byte_valid && byte_data == held, "R7 hold under stall", {byte_valid, byte_data}, {1'b1, held});
        if (!is_last) chk(wd_ready == 1'b0, "R7 input blocked while draining", 64'(wd_ready), 0);
      end
      byte_ready = 1'b1;
      chk(byte_valid == 1'b1, "R3 byte present", 64'(byte_valid), 1);
      chk(byte_data == exp_byte(o, w, pos), "R2 byte order", 64'(byte_data), 64'(exp_byte(o, w, pos)));
      chk(byte_last == (is_last && pos == n - 1), "R4 last position", 64'(byte_last), 64'(is_last && pos == n - 1));
      @(negedge clk);
      byte_ready = 1'b0;
    end
    chk(byte_valid == 1'b0, "R4 word byte count", 64'(byte_valid), 0);
    if (is_last) begin
      chk(msg_done == 1'b1, "R8 done after last byte", 64'(msg_done), 1);
      @(negedge clk);
      chk(msg_done == 1'b0, "R8 done one cycle", 64'(msg_done), 0);
    end
  endtask

  task automatic late_write(input string tag);
    send_word(32'hBAD0BAD0);
    chk(wr_err == 1'b1, tag, 64'(wr_err), 1);
    chk(byte_valid == 1'b0, tag, 64'(byte_valid), 0);
    @(negedge clk);
    chk(wr_err == 1'b0, tag, 64'(wr_err), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_order = 2'd0; cfg_len_bits = '0;
    wd_valid = 1'b0; wd_data = '0; byte_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(byte_valid == 0 && byte_last == 0, "R1 outputs idle", {byte_valid, byte_last}, 0);
    chk(msg_done == 0 && wr_err == 0, "R1 strobes low", {msg_done, wr_err}, 0);
    chk(wd_ready == 1'b1, "R1 ready when unconfigured", 64'(wd_ready), 1);

    // R5 write before any configuration
    late_write("R5 early write dropped");

    // table walk: orders, final-word sizes, back-pressure
    for (int v = 0; v < 8; v++) begin
      int nb, nw;
      nb = int'(VECS[v].nbytes);
      nw = (nb + 3) / 4;
      configure(VECS[v].ord, {53'd0, VECS[v].nbytes, 3'd0} + 64'(VECS[v].extra));
      for (int w = 0; w < nw; w++) begin
        logic [31:0] wd;
        wd = (w == 0) ? VECS[v].w0 : (w == 1) ? VECS[v].w1 : VECS[v].w2;
        send_word(wd);
        collect(wd, VECS[v].ord, (w == nw - 1) ? nb - 4 * w : 4, w == nw - 1, VECS[v].stall);
      end
    end

    // R9 word after message complete
    late_write("R9 excess write dropped");

    // R10 zero-length message
    configure(2'd1, 64'd5);
    chk(byte_valid == 1'b0, "R10 no bytes", 64'(byte_valid), 0);
    late_write("R9 write after zero-length");

    finish_up();
  end
endmodule